// File: doc/BRIEF.md
# Virtualization Maintenance Interrupt Generator

This block raises the maintenance interrupt that a hypervisor uses to keep a virtual processor's list of interrupt entries serviced. It watches the live state of every list entry, the deactivation events that the list logic reports, end-of-interrupt requests that found no matching entry, and the two virtual interrupt group enables. From these it derives eight maintenance causes. Each cause has its own enable bit, and a global virtual-interface enable gates all of them. The interrupt output is a level. It is recomputed every cycle from the current state, so it stays high for as long as any enabled cause holds.

Alongside the interrupt, the block exposes a per-entry end-of-interrupt flag vector, a per-entry free-slot vector and the vector of causes that are pending and enabled. End-of-interrupt requests that matched no entry are counted in a small saturating counter, which host software clears. Host software also clears an entry's end-of-interrupt flag by rewriting that entry. Arbitration among the entries and the physical distributor lie outside this block.

Top module: `vmaint_irq_gen`

## Requirements
- R1: While `vif_en` is 0 at a clock edge, `maint_irq` and every bit of `cause_pend` are 0 after that edge, whatever the other inputs are.
- R2: `maint_irq` equals the OR of `cause_pend`. It is a level that stays high for as long as an enabled cause holds, not a single-cycle pulse.
- R3: Group causes: bit 4 is set when `grp0_on`=1, bit 5 when `grp0_on`=0, bit 6 when `grp1_on`=1 and bit 7 when `grp1_on`=0.
- R4: Bit 3 (no pending entry) is set when no entry of `lr_state` holds encoding 01 (pending) or 11 (active and pending). The encodings are 00 inactive, 01 pending, 10 active and 11 active and pending, with entry i in bits [2i+1:2i].
- R5: Bit 1 (underflow) is set when zero entries or exactly one entry has an encoding other than 00.
- R6: `empty_status[i]` is 1 exactly when entry i was encoded 00 at the previous clock edge.
- R7: `miss_cnt` increments by one at each edge where `eoi_miss`=1 and stops at its maximum of 31. `miss_clr`=1 sets it to 0 and takes priority over a miss in the same cycle.
- R8: Bit 2 (unmatched end of interrupt) is set while `miss_cnt` is nonzero.
- R9: `eoi_status[i]` becomes 1 at the edge where `lr_deact[i]`=1 and `lr_maint_req[i]`=1 while entry i is encoded 10. A deactivation of an entry in any other encoding, or of an entry without `lr_maint_req[i]`, leaves the flag unchanged.
- R10: `lr_wr[i]`=1 clears `eoi_status[i]` at the next edge and takes priority over a setting deactivation in the same cycle.
- R11: Bit 0 (end of interrupt received) is set while any bit of `eoi_status` is 1.
- R12: While `rst_n` is 0, every output is 0.
- R13: Each `cause_pend` bit is the raw cause ANDed with the matching `cause_en` bit. The causes are evaluated from the inputs and the flag and counter state at an edge and registered there, so an input change appears one edge later and a counted or flagged event appears two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vif_en | input | 1 | Global virtual-interface enable |
| cause_en | input | 8 | Per-cause enable, same bit positions as `cause_pend` |
| grp0_on | input | 1 | Virtual group 0 enable |
| grp1_on | input | 1 | Virtual group 1 enable |
| lr_state | input | 2*NUM_LR | Live state of every list entry, 2 bits each |
| lr_maint_req | input | NUM_LR | Entry asks for maintenance when it is deactivated |
| lr_deact | input | NUM_LR | Entry is deactivated this cycle (pulse) |
| lr_wr | input | NUM_LR | Host rewrites the entry this cycle (pulse) |
| eoi_miss | input | 1 | End of interrupt with no matching entry (pulse) |
| miss_clr | input | 1 | Host clears the miss counter |
| maint_irq | output | 1 | Level-sensitive maintenance interrupt |
| cause_pend | output | 8 | Causes that are pending and enabled |
| eoi_status | output | NUM_LR | Per-entry end-of-interrupt flags |
| empty_status | output | NUM_LR | Per-entry free-slot flags |
| miss_cnt | output | CNT_W | Saturating count of unmatched end-of-interrupt requests |

## Verification
The state inside this block is limited to the end-of-interrupt flags, the miss counter and the output register, and each of them reaches the ports directly. A flag that is set or cleared wrongly shows on `eoi_status` one edge after the event, and on `cause_pend` bit 0 one edge after that. A counter that is off shows on `miss_cnt` and, at zero or at saturation, on bit 2. A decoding fault in the scan of entry states shows on `empty_status` or on bits 1 and 3 one edge after the input changes. The bench therefore sweeps every combination of entry states, every cause enable pattern with both group enables and the global enable, and it drives the counter past its saturation point.

// File: rtl/vmi_pkg.sv
package vmi_pkg;

    typedef enum logic [1:0] {
        LR_IDLE    = 2'b00,
        LR_PEND    = 2'b01,
        LR_ACT     = 2'b10,
        LR_ACTPEND = 2'b11
    } lr_st_e;

    localparam int NUM_CAUSE = 8;

    localparam int C_EOI   = 0;
    localparam int C_UNDER = 1;
    localparam int C_NOENT = 2;
    localparam int C_NOPEND = 3;
    localparam int C_G0ON  = 4;
    localparam int C_G0OFF = 5;
    localparam int C_G1ON  = 6;
    localparam int C_G1OFF = 7;

endpackage

// File: rtl/vmi_lr_scan.sv
module vmi_lr_scan
    import vmi_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic [2*NUM_LR-1:0] lr_state,
    output logic [NUM_LR-1:0]   empty_vec,
    output logic                any_pend,
    output logic                underflow
);

    logic [NUM_LR-1:0] valid_vec;
    logic [NUM_LR-1:0] pend_vec;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
        lr_st_e st;
        assign st           = lr_st_e'(lr_state[2*i +: 2]);
        assign empty_vec[i] = (st == LR_IDLE);
        assign valid_vec[i] = (st != LR_IDLE);
        assign pend_vec[i]  = (st == LR_PEND) || (st == LR_ACTPEND);
    end

    always_comb begin
        int nvalid;
        nvalid = 0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (valid_vec[i]) begin
                nvalid = nvalid + 1;
            end
        end
        underflow = (nvalid <= 1);
        any_pend  = |pend_vec;
    end

endmodule

// File: rtl/vmi_miss_ctr.sv
module vmi_miss_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_miss,
    input  logic             miss_clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (miss_clr) begin
            ctr_d.cnt = '0;
        end else if (eoi_miss && (ctr_q.cnt != CNT_MAX)) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;

endmodule

// File: rtl/vmi_eoi_flags.sv
module vmi_eoi_flags
    import vmi_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic [NUM_LR-1:0]   lr_maint_req,
    input  logic [NUM_LR-1:0]   lr_deact,
    input  logic [NUM_LR-1:0]   lr_wr,
    output logic [NUM_LR-1:0]   flags
);

    typedef struct packed {
        logic [NUM_LR-1:0] flag;
    } flg_t;

    flg_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lr_wr[i]) begin
                flg_d.flag[i] = 1'b0;
            end else if (lr_deact[i] && lr_maint_req[i] &&
                         (lr_st_e'(lr_state[2*i +: 2]) == LR_ACT)) begin
                flg_d.flag[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign flags = flg_q.flag;

endmodule

// File: rtl/vmaint_irq_gen.sv
module vmaint_irq_gen
    import vmi_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int CNT_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vif_en,
    input  logic [NUM_CAUSE-1:0] cause_en,
    input  logic                 grp0_on,
    input  logic                 grp1_on,
    input  logic [2*NUM_LR-1:0]  lr_state,
    input  logic [NUM_LR-1:0]    lr_maint_req,
    input  logic [NUM_LR-1:0]    lr_deact,
    input  logic [NUM_LR-1:0]    lr_wr,
    input  logic                 eoi_miss,
    input  logic                 miss_clr,
    output logic                 maint_irq,
    output logic [NUM_CAUSE-1:0] cause_pend,
    output logic [NUM_LR-1:0]    eoi_status,
    output logic [NUM_LR-1:0]    empty_status,
    output logic [CNT_W-1:0]     miss_cnt
);

    typedef struct packed {
        logic                 irq;
        logic [NUM_CAUSE-1:0] cause;
        logic [NUM_LR-1:0]    empty;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_LR-1:0] empty_vec;
    logic              any_pend;
    logic              underflow;
    logic [NUM_LR-1:0] flags;
    logic [CNT_W-1:0]  cnt;
    logic [NUM_CAUSE-1:0] raw;

    vmi_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
        .lr_state  (lr_state),
        .empty_vec (empty_vec),
        .any_pend  (any_pend),
        .underflow (underflow)
    );

    vmi_eoi_flags #(.NUM_LR(NUM_LR)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .lr_state     (lr_state),
        .lr_maint_req (lr_maint_req),
        .lr_deact     (lr_deact),
        .lr_wr        (lr_wr),
        .flags        (flags)
    );

    vmi_miss_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoi_miss (eoi_miss),
        .miss_clr (miss_clr),
        .cnt      (cnt)
    );

    always_comb begin
        raw           = '0;
        raw[C_EOI]    = |flags;
        raw[C_UNDER]  = underflow;
        raw[C_NOENT]  = (cnt != '0);
        raw[C_NOPEND] = !any_pend;
        raw[C_G0ON]   = grp0_on;
        raw[C_G0OFF]  = !grp0_on;
        raw[C_G1ON]   = grp1_on;
        raw[C_G1OFF]  = !grp1_on;

        out_d       = out_q;
        out_d.cause = raw & cause_en & {NUM_CAUSE{vif_en}};
        out_d.irq   = |out_d.cause;
        out_d.empty = empty_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign maint_irq    = out_q.irq;
    assign cause_pend   = out_q.cause;
    assign empty_status = out_q.empty;
    assign eoi_status   = flags;
    assign miss_cnt     = cnt;

endmodule

// File: rtl/vmi_checker.sv
module vmi_checker #(
    parameter int NUM_LR = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vif_en,
    input logic [NUM_LR-1:0] lr_wr,
    input logic              eoi_miss,
    input logic              miss_clr,
    input logic              maint_irq,
    input logic [7:0]        cause_pend,
    input logic [NUM_LR-1:0] eoi_status,
    input logic [CNT_W-1:0]  miss_cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    assert_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !vif_en |=> (!maint_irq && (cause_pend == '0)));

    assert_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        maint_irq == (|cause_pend));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt == CNT_TOP && !miss_clr) |=> (miss_cnt == CNT_TOP));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_clr |=> (miss_cnt == '0));

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_miss && !miss_clr && miss_cnt != CNT_TOP)
            |=> (miss_cnt == $past(miss_cnt) + 1'b1));

    for (genvar i = 0; i < NUM_LR; i++) begin : g_wr
        assert_wr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            lr_wr[i] |=> !eoi_status[i]);
    end

endmodule

bind vmaint_irq_gen vmi_checker #(.NUM_LR(NUM_LR), .CNT_W(CNT_W)) u_vmi_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .vif_en     (vif_en),
    .lr_wr      (lr_wr),
    .eoi_miss   (eoi_miss),
    .miss_clr   (miss_clr),
    .maint_irq  (maint_irq),
    .cause_pend (cause_pend),
    .eoi_status (eoi_status),
    .miss_cnt   (miss_cnt)
);

// File: tb/test_vmaint_irq_gen.sv
`timescale 1ns/1ps
module test_vmaint_irq_gen;

    localparam int NLR = 4;
    localparam int CW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           vif_en = 1'b0;
    logic [7:0]     cause_en = '0;
    logic           grp0_on = 1'b0;
    logic           grp1_on = 1'b0;
    logic [2*NLR-1:0] lr_state = '0;
    logic [NLR-1:0] lr_maint_req = '0;
    logic [NLR-1:0] lr_deact = '0;
    logic [NLR-1:0] lr_wr = '0;
    logic           eoi_miss = 1'b0;
    logic           miss_clr = 1'b0;
    logic           maint_irq;
    logic [7:0]     cause_pend;
    logic [NLR-1:0] eoi_status;
    logic [NLR-1:0] empty_status;
    logic [CW-1:0]  miss_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vmaint_irq_gen #(.NUM_LR(NLR), .CNT_W(CW)) i_vmaint_irq_gen (
        .clk(clk), .rst_n(rst_n), .vif_en(vif_en), .cause_en(cause_en),
        .grp0_on(grp0_on), .grp1_on(grp1_on), .lr_state(lr_state),
        .lr_maint_req(lr_maint_req), .lr_deact(lr_deact), .lr_wr(lr_wr),
        .eoi_miss(eoi_miss), .miss_clr(miss_clr), .maint_irq(maint_irq),
        .cause_pend(cause_pend), .eoi_status(eoi_status),
        .empty_status(empty_status), .miss_cnt(miss_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // raw cause model from the requirement text (bit positions per R3-R5, R8, R11)
    function automatic logic [7:0] model(input logic [7:0] st, input logic g0, input logic g1,
                                         input logic flag_any, input logic cnt_nz);
        int nv = 0;
        int np = 0;
        logic [7:0] r;
        for (int i = 0; i < NLR; i++) begin
            if (st[2*i +: 2] != 2'b00) nv++;
            if (st[2*i] == 1'b1) np++;
        end
        r    = '0;
        r[0] = flag_any;
        r[1] = (nv <= 1);
        r[2] = cnt_nz;
        r[3] = (np == 0);
        r[4] = g0;
        r[5] = !g0;
        r[6] = g1;
        r[7] = !g1;
        return r;
    endfunction

    function automatic logic [3:0] empties(input logic [7:0] st);
        logic [3:0] e;
        for (int i = 0; i < NLR; i++) e[i] = (st[2*i +: 2] == 2'b00);
        return e;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] exp;
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12 irq", {31'd0, maint_irq}, 0);
        chk("R12 cause", {24'd0, cause_pend}, 0);
        chk("R12 eoi", {28'd0, eoi_status}, 0);
        chk("R12 empty", {28'd0, empty_status}, 0);
        chk("R12 cnt", {27'd0, miss_cnt}, 0);
        rst_n = 1'b1;

        // R4 R5 R6: sweep every entry state combination
        vif_en = 1'b1; cause_en = 8'hFF; grp0_on = 1'b1; grp1_on = 1'b1;
        for (int s = 0; s < 256; s++) begin
            @(negedge clk);
            lr_state = 8'(s);
            @(negedge clk);
            exp = model(8'(s), 1'b1, 1'b1, 1'b0, 1'b0);
            chk("R6 empty", {28'd0, empty_status}, {28'd0, empties(8'(s))});
            chk("R4 R5 R3 cause", {24'd0, cause_pend}, {24'd0, exp});
            chk("R2 irq", {31'd0, maint_irq}, {31'd0, |exp});
        end

        // R1 R3 R13: sweep enables, groups and global enable
        for (int g = 0; g < 2; g++) begin
            for (int gp = 0; gp < 4; gp++) begin
                for (int e = 0; e < 256; e++) begin
                    @(negedge clk);
                    lr_state = 8'b0000_0010;
                    vif_en = g[0]; grp0_on = gp[0]; grp1_on = gp[1]; cause_en = 8'(e);
                    @(negedge clk);
                    exp = model(8'b0000_0010, gp[0], gp[1], 1'b0, 1'b0) & 8'(e) & {8{g[0]}};
                    chk("R13 R1 R3 cause", {24'd0, cause_pend}, {24'd0, exp});
                    chk("R2 R1 irq", {31'd0, maint_irq}, {31'd0, |exp});
                end
            end
        end

        // R7 R8: miss counter
        @(negedge clk);
        vif_en = 1'b1; cause_en = 8'b0000_0100; lr_state = 8'b1010_1010;
        @(negedge clk);
        chk("R8 idle", {31'd0, maint_irq}, 0);
        eoi_miss = 1'b1;
        @(negedge clk);
        eoi_miss = 1'b0;
        chk("R7 first", {27'd0, miss_cnt}, 1);
        @(negedge clk);
        chk("R8 cause", {24'd0, cause_pend}, 32'h4);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 level held", {31'd0, maint_irq}, 1);
        end
        eoi_miss = 1'b1;
        for (int k = 2; k <= 40; k++) begin
            @(negedge clk);
            chk("R7 count", {27'd0, miss_cnt}, (k > 31) ? 31 : k);
        end
        miss_clr = 1'b1;
        @(negedge clk);
        chk("R7 clear wins", {27'd0, miss_cnt}, 0);
        miss_clr = 1'b0; eoi_miss = 1'b0;
        @(negedge clk);
        chk("R8 gone", {24'd0, cause_pend}, 0);
        chk("R2 low", {31'd0, maint_irq}, 0);

        // R9 R10 R11: end-of-interrupt flags
        cause_en = 8'b0000_0001;
        lr_state = 8'b00_10_11_10;   // e3 idle, e2 active, e1 act+pend, e0 active
        lr_maint_req = 4'b1111;
        lr_deact = 4'b1110;          // e0 not deactivated
        @(negedge clk);
        lr_deact = '0;
        chk("R9 set only active", {28'd0, eoi_status}, 32'b0100);
        @(negedge clk);
        chk("R11 cause", {24'd0, cause_pend}, 1);
        lr_maint_req = 4'b1110;
        lr_deact = 4'b0001;          // e0 active but no maintenance request
        @(negedge clk);
        lr_deact = '0;
        chk("R9 no request", {28'd0, eoi_status}, 32'b0100);
        lr_maint_req = 4'b1111;
        lr_deact = 4'b0001;
        @(negedge clk);
        lr_deact = '0;
        chk("R9 set e0", {28'd0, eoi_status}, 32'b0101);
        lr_wr = 4'b0001;
        @(negedge clk);
        lr_wr = '0;
        chk("R10 clear e0", {28'd0, eoi_status}, 32'b0100);
        lr_wr = 4'b0100; lr_deact = 4'b0100;
        @(negedge clk);
        lr_wr = '0; lr_deact = '0;
        chk("R10 write wins", {28'd0, eoi_status}, 0);
        @(negedge clk);
        chk("R11 cleared", {24'd0, cause_pend}, 0);

        // R1: flags stay but global enable removes the interrupt
        cause_en = 8'hFF;
        lr_deact = 4'b0001;
        @(negedge clk);
        lr_deact = '0;
        vif_en = 1'b0;
        @(negedge clk);
        chk("R1 gated irq", {31'd0, maint_irq}, 0);
        chk("R9 flag kept", {28'd0, eoi_status}, 32'b0001);

        summary();
        $finish;
    end

endmodule